// File: doc/BRIEF.md
# Drum Rotational Latency Calculator

This block works out how many word-times a sequencer must idle before it issues the next instruction on a rotating memory. A track has 64 sectors. Logical sectors are interlaced across the physical ring. Each request carries four things: the address of the instruction now executing, the address of the next instruction, the operand address and the 4-bit opcode. The block maps all three sector numbers to physical positions. It then measures how far ahead the next instruction and the operand lie, and returns a delay count.

The operand distance is compared against a window whose bounds depend on the opcode. If the operand falls inside the window, it can be reached on the way to the next instruction, and the delay is the instruction distance less one. If it falls outside, one more full revolution is added. Two opcodes (hex A and B) have no operand fetch, so their operand address is ignored. The result is registered and appears with a valid strobe one clock after the request. A new request may be issued on every clock.

Top module: `drum_latency`

## Requirements
- R1: During and just after a synchronous active-high reset, `dly_valid` is 0 and `dly_count` is 0.
- R2: `dly_valid` is high in exactly those cycles that follow a cycle with `req_valid` high and reset low.
- R3: Only the low 6 bits of each address select a sector; the upper address bits have no effect on `dly_count`.
- R4: Logical sector L sits at physical sector (64 − 7·L) mod 64, so the sequence is 0, 57, 50, 43, …
- R5: The instruction distance and the operand distance are each (target physical − current physical) mod 64.
- R6: For opcodes 0xA and 0xB the operand is ignored. The delay is instruction distance − 1 when that distance is 2 or more, and instruction distance + 63 otherwise.
- R7: For every other opcode, the delay is instruction distance − 1 when the operand distance lies in [2, max] inclusive, and instruction distance + 63 otherwise.
- R8: The window maximum per opcode 0x0..0xF is 7,7,7,7,7,5,8,6,7,7,0,0,7,7,7,7, and the minimum is 2 for all opcodes.
- R9: When the next-instruction sector equals the current sector (distance 0), the delay is 63 for every opcode and operand.
- R10: In a cycle with no request, `dly_count` keeps the value it held before that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one per clock allowed |
| cur_addr | input | 12 | Address of the executing instruction |
| next_addr | input | 12 | Address of the next instruction |
| opnd_addr | input | 12 | Operand address |
| opcode | input | 4 | Instruction opcode |
| dly_valid | output | 1 | Result strobe, one clock after the request |
| dly_count | output | 7 | Word-times to wait (0..126) |

## Verification
The window edges are the hardest cases to reach from the ports. A random operand address rarely lands at exactly physical distance 2 or at the opcode's maximum, because the interlace scatters consecutive logical sectors by 7. The stimulus therefore sweeps every current sector against every operand sector for all sixteen opcodes, which places each window boundary in front of the comparator. Separate runs cover a zero instruction distance, operand-free opcodes with random operands, upper-address noise, and idle gaps between requests.

// File: rtl/lat_pkg.sv
package lat_pkg;

  localparam int OP_W  = 4;
  localparam int WIN_W = 4;

  typedef logic [OP_W-1:0]  opcode_t;
  typedef logic [WIN_W-1:0] winmax_t;

  // Upper edge of the operand window for each opcode; zero means no operand fetch.
  function automatic winmax_t window_max(input opcode_t op);
    winmax_t m;
    case (op)
      4'h5:          m = 4'd5;
      4'h6:          m = 4'd8;
      4'h7:          m = 4'd6;
      4'hA, 4'hB:    m = 4'd0;
      default:       m = 4'd7;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/lat_interlace.sv
module lat_interlace #(
  parameter int SECT_W = 6,
  parameter int STRIDE = 7
) (
  input  logic [SECT_W-1:0] logical_sect,
  output logic [SECT_W-1:0] physical_sect
);
  localparam int NSECT = 1 << SECT_W;
  localparam logic [SECT_W-1:0] BACKSTEP = SECT_W'(NSECT - STRIDE);

  // Each logical step moves the physical position back by STRIDE around the ring.
  always_comb physical_sect = logical_sect * BACKSTEP;
endmodule

// File: rtl/lat_distance.sv
module lat_distance #(
  parameter int SECT_W = 6
) (
  input  logic [SECT_W-1:0] from_sect,
  input  logic [SECT_W-1:0] to_sect,
  output logic [SECT_W-1:0] ahead
);
  // Modular difference: truncation to SECT_W bits provides the wrap.
  always_comb ahead = to_sect - from_sect;
endmodule

// File: rtl/lat_window.sv
module lat_window #(
  parameter int SECT_W  = 6,
  parameter int WIN_MIN = 2
) (
  input  lat_pkg::opcode_t  opcode,
  input  logic [SECT_W-1:0] opnd_ahead,
  input  logic [SECT_W-1:0] pc_ahead,
  output logic              on_time
);
  import lat_pkg::*;

  winmax_t           hi;
  logic [SECT_W-1:0] hi_ext;
  logic [SECT_W-1:0] lo_ext;
  logic              opnd_fits;
  logic              pc_fits;

  always_comb begin
    hi        = window_max(opcode);
    hi_ext    = SECT_W'(hi);
    lo_ext    = SECT_W'(WIN_MIN);
    opnd_fits = (opnd_ahead >= lo_ext) && (opnd_ahead <= hi_ext);
    pc_fits   = (pc_ahead >= lo_ext);
    if (pc_ahead == '0)
      on_time = 1'b0;
    else if (hi == '0)
      on_time = pc_fits;
    else
      on_time = opnd_fits;
  end
endmodule

// File: rtl/drum_latency.sv
module drum_latency #(
  parameter int ADDR_W  = 12,
  parameter int SECT_W  = 6,
  parameter int STRIDE  = 7,
  parameter int WIN_MIN = 2,
  parameter int DLY_W   = SECT_W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [ADDR_W-1:0]    cur_addr,
  input  logic [ADDR_W-1:0]    next_addr,
  input  logic [ADDR_W-1:0]    opnd_addr,
  input  logic [3:0]           opcode,
  output logic                 dly_valid,
  output logic [DLY_W-1:0]     dly_count
);
  import lat_pkg::*;

  localparam int NSECT = 1 << SECT_W;
  localparam int NPOS  = 3;
  localparam int IDX_CUR = 0;
  localparam int IDX_NXT = 1;
  localparam int IDX_OPD = 2;

  logic [SECT_W-1:0] log_sect  [NPOS];
  logic [SECT_W-1:0] phys_sect [NPOS];
  logic [SECT_W-1:0] pc_ahead;
  logic [SECT_W-1:0] opnd_ahead;
  logic              on_time;
  logic [DLY_W-1:0]  pc_wide;
  logic [DLY_W-1:0]  next_count;

  always_comb begin
    log_sect[IDX_CUR] = cur_addr[SECT_W-1:0];
    log_sect[IDX_NXT] = next_addr[SECT_W-1:0];
    log_sect[IDX_OPD] = opnd_addr[SECT_W-1:0];
  end

  for (genvar g = 0; g < NPOS; g++) begin : g_map
    lat_interlace #(.SECT_W(SECT_W), .STRIDE(STRIDE)) u_map (
      .logical_sect  (log_sect[g]),
      .physical_sect (phys_sect[g])
    );
  end

  lat_distance #(.SECT_W(SECT_W)) u_pc_dist (
    .from_sect (phys_sect[IDX_CUR]),
    .to_sect   (phys_sect[IDX_NXT]),
    .ahead     (pc_ahead)
  );

  lat_distance #(.SECT_W(SECT_W)) u_opnd_dist (
    .from_sect (phys_sect[IDX_CUR]),
    .to_sect   (phys_sect[IDX_OPD]),
    .ahead     (opnd_ahead)
  );

  lat_window #(.SECT_W(SECT_W), .WIN_MIN(WIN_MIN)) u_win (
    .opcode     (opcode_t'(opcode)),
    .opnd_ahead (opnd_ahead),
    .pc_ahead   (pc_ahead),
    .on_time    (on_time)
  );

  always_comb begin
    pc_wide    = DLY_W'(pc_ahead);
    next_count = on_time ? (pc_wide - DLY_W'(1))
                         : (pc_wide + DLY_W'(NSECT - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dly_valid <= 1'b0;
      dly_count <= '0;
    end else begin
      dly_valid <= req_valid;
      if (req_valid)
        dly_count <= next_count;
    end
  end
endmodule

// File: rtl/lat_checker.sv
module lat_checker #(
  parameter int ADDR_W = 12,
  parameter int SECT_W = 6,
  parameter int DLY_W  = SECT_W + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [ADDR_W-1:0] next_addr,
  input logic              dly_valid,
  input logic [DLY_W-1:0]  dly_count
);
  localparam int NSECT   = 1 << SECT_W;
  localparam int MAX_DLY = 2 * NSECT - 2;

  // R1: reset clears both outputs
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (!dly_valid && dly_count == '0));

  // R2: one result strobe per request, one cycle later
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> dly_valid);

  // R2: no strobe without a request
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !dly_valid);

  // R10: count stays put across idle cycles
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(dly_count));

  // R9: same sector for current and next gives a full revolution less one
  p_zero_dist_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && cur_addr[SECT_W-1:0] == next_addr[SECT_W-1:0])
      |=> (dly_count == DLY_W'(NSECT - 1)));

  // R7: the result never exceeds two revolutions less two
  p_count_range_r7: assert property (@(posedge clk) disable iff (rst)
    dly_valid |-> (dly_count <= DLY_W'(MAX_DLY)));
endmodule

bind drum_latency lat_checker #(
  .ADDR_W (ADDR_W),
  .SECT_W (SECT_W),
  .DLY_W  (DLY_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .cur_addr  (cur_addr),
  .next_addr (next_addr),
  .dly_valid (dly_valid),
  .dly_count (dly_count)
);

// File: tb/sim_drum_latency.sv
module sim_drum_latency;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [11:0] cur_addr = '0;
  logic [11:0] next_addr = '0;
  logic [11:0] opnd_addr = '0;
  logic [3:0]  opcode = '0;
  logic        dly_valid;
  logic [6:0]  dly_count;

  int    n_checks = 0;
  int    n_fail = 0;
  bit    armed = 0;
  bit    exp_v = 0;
  int    exp_c = 0;
  string cur_tag = "R1";

  always #4 clk = ~clk;

  drum_latency u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid),
    .cur_addr(cur_addr), .next_addr(next_addr), .opnd_addr(opnd_addr),
    .opcode(opcode), .dly_valid(dly_valid), .dly_count(dly_count)
  );

  // Physical position by walking the ring 57 places per logical step.
  function automatic int phys_of(input int a);
    int p = 0;
    for (int i = 0; i < (a % 64); i++) p = (p + 57) % 64;
    return p;
  endfunction

  function automatic int win_hi(input int op);
    case (op)
      5: return 5;
      6: return 8;
      7: return 6;
      10, 11: return 0;
      default: return 7;
    endcase
  endfunction

  function automatic int ref_delay(input int c, input int n, input int o, input int op);
    int pc, pn, po, dpc, dop, hi;
    bit ok;
    pc = phys_of(c); pn = phys_of(n); po = phys_of(o);
    dpc = (pn - pc + 64) % 64;
    dop = (po - pc + 64) % 64;
    if (dpc == 0) return 63;
    hi = win_hi(op);
    if (hi == 0) ok = (dpc >= 2);
    else         ok = (dop >= 2) && (dop <= hi);
    return ok ? dpc - 1 : dpc + 63;
  endfunction

  // One clock: check what the previous drive produced, then drive anew.
  task automatic cyc(input bit r, input bit v, input int c, input int n,
                     input int o, input int op);
    @(negedge clk);
    if (armed) begin
      n_checks++;
      if (dly_valid !== exp_v) begin
        n_fail++;
        $display("FAIL %s R2 dly_valid actual=%0d expected=%0d", cur_tag, dly_valid, exp_v);
      end
      n_checks++;
      if (int'(dly_count) != exp_c) begin
        n_fail++;
        $display("FAIL %s dly_count actual=%0d expected=%0d", cur_tag, dly_count, exp_c);
      end
    end
    rst = r; req_valid = v;
    cur_addr = 12'(c); next_addr = 12'(n); opnd_addr = 12'(o); opcode = 4'(op);
    if (r) begin exp_v = 0; exp_c = 0; end
    else if (v) begin exp_v = 1; exp_c = ref_delay(c, n, o, op); end
    else exp_v = 0;
    armed = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    cur_tag = "R1";
    repeat (4) cyc(1, 1, 3, 9, 20, 1);
    cyc(0, 0, 0, 0, 0, 0);
    // R4 R5 R7 R8: every current sector against every operand sector, all opcodes
    cur_tag = "R4 R5 R7 R8 sweep";
    for (int op = 0; op < 16; op++)
      for (int c = 0; c < 64; c++)
        for (int o = 0; o < 64; o++)
          cyc(0, 1, c, (c + 1 + op) % 64, o, op);
    // R9: next sector equals current sector
    cur_tag = "R9";
    for (int op = 0; op < 16; op++)
      for (int c = 0; c < 64; c += 7)
        cyc(0, 1, c, c, (c * 3) % 64, op);
    // R6: operand-free opcodes with random operands and next sectors
    cur_tag = "R6";
    for (int i = 0; i < 2000; i++)
      cyc(0, 1, $urandom_range(0, 63), $urandom_range(0, 63),
          $urandom_range(0, 4095), 10 + (i % 2));
    // R3: upper address bits carry noise
    cur_tag = "R3";
    for (int i = 0; i < 4000; i++)
      cyc(0, 1, $urandom_range(0, 4095), $urandom_range(0, 4095),
          $urandom_range(0, 4095), $urandom_range(0, 15));
    // R10 R2: requests with idle gaps changing inputs
    cur_tag = "R10 R2";
    for (int i = 0; i < 3000; i++)
      cyc(0, (i % 3) == 0, $urandom_range(0, 4095), $urandom_range(0, 4095),
          $urandom_range(0, 4095), $urandom_range(0, 15));
    // R1: reset in mid stream
    cur_tag = "R1 mid";
    cyc(1, 1, 5, 40, 7, 2);
    cyc(1, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule